// File: doc/BRIEF.md
# Wake-Up Frame Pattern Matcher

This block watches a receive stream that arrives as 32-bit dwords and decides whether a frame carries one of up to eight stored wake-up patterns. The patterns sit in a 64-word by 40-bit pattern memory. Software loads the memory through a write port while pattern mode is off. Words 0 and 1 hold a table of start pointers and a per-pattern enable byte. Every later word holds four pattern bytes and a control byte. The control byte gives an end-of-pattern flag, a dword skip count and a per-byte compare mask.

Each pattern has its own tracker, and all trackers step through the same frame in parallel. A tracker starts at the pattern's pointer on the first dword of a frame. It passes over the number of frame dwords its current word asks for, then compares the next dword against the word's unmasked bytes. On a match it moves to the following word. On a mismatch it drops out for the rest of the frame. When any tracker matches a word flagged as the end of its pattern, a sticky match-detect status is set. A sticky power-management status is set in the same edge. That status drives the wake output while power-management enable is high.

Top module: `wake_pattern_matcher`

## Requirements
- R1: When `mem_we_i` is high and `pmat_mode_i` is low, the 40-bit `mem_wdata_i` is stored at `mem_addr_i`. A write attempted while `pmat_mode_i` is high leaves the memory unchanged.
- R2: Pattern k takes part in matching only when bit k of word 0 is 1. A disabled pattern never produces a match, even if its words would match every dword.
- R3: The start address of pattern k is taken from the low 6 bits of a pointer byte. For k = 0..3 that byte is bits [8k+15:8k+8] of word 0. For k = 4..7 it is bits [8(k-4)+15:8(k-4)+8] of word 1.
- R4: In a pattern word, bit 7 is the end-of-pattern flag, bits 6:4 are a skip count S (0..7) and bits 3:0 are the byte mask. Before the word is compared, the tracker passes over S frame dwords.
- R5: Pattern byte n sits in word bits [8n+15:8n+8] and is compared with dword bits [8n+7:8n]. When mask bit n is 0, that byte is ignored.
- R6: A mismatch on any unmasked byte ends that pattern's attempt for the rest of the frame. A later matching dword in the same frame does not revive it. A frame that ends, meaning the next `sof_i` arrives, before the end-of-pattern word has matched gives no match.
- R7: Dwords are examined only while `pmat_mode_i`, `rx_run_i` and `rx_susp_i` are all 1. Otherwise dwords are ignored and every tracker is idle.
- R8: `match_det_o` goes high on the clock edge that accepts a dword completing any enabled pattern. It stays high until `det_clr_i` is seen at an edge with no new completion. A completion at the same edge as a clear keeps it high.
- R9: `pm_status_o` is set at the same edge as `match_det_o` and is cleared only by `pm_clr_i`. `wake_o` is high exactly when `pm_status_o` and `pm_en_i` are both high.
- R10: After reset `match_det_o`, `pm_status_o` and `wake_o` are 0 and no tracker is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pmat_mode_i | input | 1 | Pattern-match mode enable; also locks the memory against writes |
| rx_run_i | input | 1 | Receive path running |
| rx_susp_i | input | 1 | Receive path suspended |
| mem_we_i | input | 1 | Pattern memory write strobe |
| mem_addr_i | input | 6 | Pattern memory word address |
| mem_wdata_i | input | 40 | Pattern memory write data |
| sof_i | input | 1 | First dword of a frame; valid together with dw_valid_i |
| dw_valid_i | input | 1 | Frame dword valid |
| dw_data_i | input | 32 | Frame dword, byte n in bits [8n+7:8n] |
| det_clr_i | input | 1 | Clear for match-detect status (write-1 pulse) |
| pm_clr_i | input | 1 | Clear for power-management status |
| pm_en_i | input | 1 | Power-management wake enable |
| match_det_o | output | 1 | Sticky match-detect status |
| pm_status_o | output | 1 | Sticky power-management status |
| wake_o | output | 1 | Wake request |

## Verification
The bench loads five patterns: a plain two-word pattern, a single masked word behind a two-dword skip, a two-word pattern with a skip on its second word, a disabled always-matching pattern, and a pattern reached through the second pointer word. Paired frames separate honoured skips from ignored ones: the same data one dword early must fail. A frame that mismatches and then carries the right data separates a killed tracker from one that retries. A frame split by a new start strobe separates frame restart from continuation. Further frames are sent with the receive gate closed, with a memory write attempted while locked, and with a clear landing on the completing dword. Wake enable is toggled to show that status and wake are kept apart.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int unsigned CTRL_W = 8;

  typedef struct packed {
    logic       eop;
    logic [2:0] skip;
    logic [3:0] mask;
  } ctrl_t;
endpackage

// File: rtl/wpm_pat_mem.sv
module wpm_pat_mem #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WORD_W = 40,
  parameter int unsigned NUM_RD = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           lock_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0]      raddr_i,
  output logic [NUM_RD-1:0][WORD_W-1:0]  rdata_o,
  output logic [NUM_RD-1:0]              en_o,
  output logic [NUM_RD-1:0][AW-1:0]      ptr_o
);
  localparam int unsigned PER_WORD = 4;

  // no reset: contents survive reset
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && !lock_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_port
    localparam int unsigned TW = g / PER_WORD;
    localparam int unsigned PB = 8 * (g % PER_WORD + 1);
    assign rdata_o[g] = mem[raddr_i[g]];
    assign ptr_o[g]   = mem[TW][PB +: AW];
    assign en_o[g]    = mem[0][g];
  end
endmodule

// File: rtl/wpm_tracker.sv
module wpm_tracker
  import wpm_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6,
  localparam int unsigned NB  = DW / 8,
  localparam int unsigned WW  = DW + CTRL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          en_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [DW-1:0] data_i,
  input  logic [WW-1:0] word_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          hit_o
);
  logic          act_q, act_c, act_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [2:0]    cnt_q, cnt_c, cnt_n;
  ctrl_t         ctrl;
  logic [DW-1:0] pat;
  logic [NB-1:0] byte_ok;
  logic          skipping, cmp_ok;

  assign act_c     = sof_i ? en_i  : act_q;
  assign rd_addr_o = sof_i ? ptr_i : addr_q;
  assign cnt_c     = sof_i ? 3'd0  : cnt_q;
  assign ctrl      = ctrl_t'(word_i[CTRL_W-1:0]);
  assign pat       = word_i[WW-1:CTRL_W];

  always_comb begin
    for (int n = 0; n < NB; n++) begin
      byte_ok[n] = !ctrl.mask[n] || (pat[8*n +: 8] == data_i[8*n +: 8]);
    end
  end

  assign skipping = cnt_c < ctrl.skip;
  assign cmp_ok   = &byte_ok;
  assign hit_o    = gate_i && valid_i && act_c && !skipping && cmp_ok && ctrl.eop;

  always_comb begin
    act_n  = act_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    if (!gate_i) begin
      act_n = 1'b0;
    end else if (valid_i) begin
      act_n  = act_c;
      addr_n = rd_addr_o;
      cnt_n  = cnt_c;
      if (act_c) begin
        if (skipping) begin
          cnt_n = cnt_c + 3'd1;
        end else if (!cmp_ok || ctrl.eop) begin
          act_n = 1'b0;
        end else begin
          addr_n = rd_addr_o + AW'(1);
          cnt_n  = 3'd0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/wpm_status.sv
module wpm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic det_clr_i,
  input  logic pm_clr_i,
  input  logic pm_en_i,
  output logic det_o,
  output logic pm_o,
  output logic wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_o <= 1'b0;
      pm_o  <= 1'b0;
    end else begin
      det_o <= hit_i || (det_o && !det_clr_i);
      pm_o  <= hit_i || (pm_o && !pm_clr_i);
    end
  end

  assign wake_o = pm_o && pm_en_i;
endmodule

// File: rtl/wake_pattern_matcher.sv
module wake_pattern_matcher #(
  parameter int unsigned NUM_PAT = 8,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 32,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned WW     = DW + wpm_pkg::CTRL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pmat_mode_i,
  input  logic          rx_run_i,
  input  logic          rx_susp_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [WW-1:0] mem_wdata_i,
  input  logic          sof_i,
  input  logic          dw_valid_i,
  input  logic [DW-1:0] dw_data_i,
  input  logic          det_clr_i,
  input  logic          pm_clr_i,
  input  logic          pm_en_i,
  output logic          match_det_o,
  output logic          pm_status_o,
  output logic          wake_o
);
  logic                           gate;
  logic [NUM_PAT-1:0][AW-1:0]     rd_addr;
  logic [NUM_PAT-1:0][WW-1:0]     rd_word;
  logic [NUM_PAT-1:0]             pat_en;
  logic [NUM_PAT-1:0][AW-1:0]     pat_ptr;
  logic [NUM_PAT-1:0]             hit;

  assign gate = pmat_mode_i && rx_run_i && rx_susp_i;

  wpm_pat_mem #(.DEPTH(DEPTH), .WORD_W(WW), .NUM_RD(NUM_PAT)) u_mem (
    .clk_i   (clk_i),
    .lock_i  (pmat_mode_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_word),
    .en_o    (pat_en),
    .ptr_o   (pat_ptr)
  );

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_trk
    wpm_tracker #(.DW(DW), .AW(AW)) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gate_i    (gate),
      .valid_i   (dw_valid_i),
      .sof_i     (sof_i),
      .en_i      (pat_en[k]),
      .ptr_i     (pat_ptr[k]),
      .data_i    (dw_data_i),
      .word_i    (rd_word[k]),
      .rd_addr_o (rd_addr[k]),
      .hit_o     (hit[k])
    );
  end

  wpm_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (|hit),
    .det_clr_i (det_clr_i),
    .pm_clr_i  (pm_clr_i),
    .pm_en_i   (pm_en_i),
    .det_o     (match_det_o),
    .pm_o      (pm_status_o),
    .wake_o    (wake_o)
  );
endmodule

// File: rtl/wake_pattern_matcher_chk.sv
module wake_pattern_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pmat_mode_i,
  input logic rx_run_i,
  input logic rx_susp_i,
  input logic dw_valid_i,
  input logic det_clr_i,
  input logic pm_clr_i,
  input logic pm_en_i,
  input logic match_det_o,
  input logic pm_status_o,
  input logic wake_o
);
  logic live;
  assign live = pmat_mode_i && rx_run_i && rx_susp_i && dw_valid_i;

  AST_DET_NEEDS_LIVE_DWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_det_o && !live) |=> !match_det_o); // R7
  AST_DET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_det_o && !det_clr_i) |=> match_det_o); // R8
  AST_DET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_clr_i && !live) |=> !match_det_o); // R8
  AST_PM_WITH_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_det_o) |-> pm_status_o); // R9
  AST_PM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_status_o && !pm_clr_i) |=> pm_status_o); // R9
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pm_en_i |-> !wake_o); // R9
endmodule

bind wake_pattern_matcher wake_pattern_matcher_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pmat_mode_i (pmat_mode_i),
  .rx_run_i    (rx_run_i),
  .rx_susp_i   (rx_susp_i),
  .dw_valid_i  (dw_valid_i),
  .det_clr_i   (det_clr_i),
  .pm_clr_i    (pm_clr_i),
  .pm_en_i     (pm_en_i),
  .match_det_o (match_det_o),
  .pm_status_o (pm_status_o),
  .wake_o      (wake_o)
);

// File: tb/wake_pattern_matcher_tb.sv
module wake_pattern_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, run = 1'b0, susp = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  waddr = '0;
  logic [39:0] wdata = '0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [31:0] data = '0;
  logic        det_clr = 1'b0, pm_clr = 1'b0, pm_en = 1'b0;
  logic        det, pm, wake;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wake_pattern_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pmat_mode_i(mode), .rx_run_i(run), .rx_susp_i(susp),
    .mem_we_i(we), .mem_addr_i(waddr), .mem_wdata_i(wdata), .sof_i(sof),
    .dw_valid_i(vld), .dw_data_i(data), .det_clr_i(det_clr), .pm_clr_i(pm_clr),
    .pm_en_i(pm_en), .match_det_o(det), .pm_status_o(pm), .wake_o(wake)
  );

  // behavioural reference
  logic [39:0] m_mem [64];
  bit          m_act [8];
  int          m_addr [8];
  int          m_cnt [8];
  bit          m_det, m_pm, m_hit, m_ok;
  logic [39:0] m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_det = 0; m_pm = 0;
      for (int k = 0; k < 8; k++) begin m_act[k] = 0; m_addr[k] = 0; m_cnt[k] = 0; end
    end else begin
      m_hit = 0;
      if (!(mode && run && susp)) begin
        for (int k = 0; k < 8; k++) m_act[k] = 0;
      end else if (vld) begin
        for (int k = 0; k < 8; k++) begin
          if (sof) begin
            m_act[k] = m_mem[0][k];
            m_addr[k] = (k < 4) ? int'(m_mem[0][8*(k+1) +: 6]) : int'(m_mem[1][8*(k-3) +: 6]);
            m_cnt[k] = 0;
          end
          if (m_act[k]) begin
            m_w = m_mem[m_addr[k]];
            if (m_cnt[k] < int'(m_w[6:4])) m_cnt[k]++;
            else begin
              m_ok = 1;
              for (int n = 0; n < 4; n++)
                if (m_w[n] && (m_w[8*n+8 +: 8] != data[8*n +: 8])) m_ok = 0;
              if (!m_ok) m_act[k] = 0;
              else if (m_w[7]) begin m_hit = 1; m_act[k] = 0; end
              else begin m_addr[k] = (m_addr[k] + 1) % 64; m_cnt[k] = 0; end
            end
          end
        end
      end
      m_det = m_hit || (m_det && !det_clr);
      m_pm  = m_hit || (m_pm && !pm_clr);
      if (we && !mode) m_mem[waddr] = wdata;
    end
  end

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 match_det model", det, m_det);
      chk("R9 pm_status model", pm, m_pm);
      chk("R9 wake model", wake, m_pm && pm_en);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [39:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic frame(input int n, input logic [31:0] d0, input logic [31:0] d1,
                       input logic [31:0] d2, input bit clr_last);
    logic [31:0] dd [3];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sof = (i == 0); vld = 1; data = dd[i];
      det_clr = clr_last && (i == n - 1);
    end
    @(negedge clk); sof = 0; vld = 0; data = '0; det_clr = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); det_clr = 1; pm_clr = 1;
    @(negedge clk); det_clr = 0; pm_clr = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset match_det", det, 0);
    chk("R10 reset pm_status", pm, 0);
    chk("R10 reset wake", wake, 0);
    // R1 load memory with mode off
    for (int a = 0; a < 64; a++) wr(6'(a), 40'h0);
    wr(6'd0,  {8'd10, 8'd8, 8'd5, 8'd2, 8'h17});    // R3 enables 0,1,2,4
    wr(6'd1,  {8'd15, 8'd14, 8'd13, 8'd12, 8'h00}); // R3 second pointer word
    wr(6'd2,  {32'hAABBCCDD, 8'h0F});
    wr(6'd3,  {32'h11223344, 8'h8F});
    wr(6'd5,  {32'h00005566, 8'hA3});               // R4 skip 2, R5 mask 3
    wr(6'd8,  {32'hCAFEF00D, 8'h0F});
    wr(6'd9,  {32'h12345678, 8'h9F});               // R4 skip 1 on second word
    wr(6'd10, {32'h00000000, 8'h80});               // R2 disabled, matches all
    wr(6'd12, {32'hDEADBEEF, 8'h8F});
    mode = 1; run = 1; susp = 1;
    @(negedge clk);

    frame(2, 32'hAABBCCDD, 32'h11223344, 0, 0);
    chk("R4 two-word pattern match", det, 1);
    chk("R9 wake held off by enable", wake, 0);
    @(negedge clk); pm_en = 1; @(negedge clk);
    chk("R9 wake with enable", wake, 1);
    @(negedge clk); det_clr = 1; @(negedge clk); det_clr = 0; @(negedge clk);
    chk("R8 det cleared", det, 0);
    chk("R9 pm survives det clear", pm, 1);
    @(negedge clk); pm_clr = 1; @(negedge clk); pm_clr = 0; @(negedge clk);
    chk("R9 pm cleared", pm, 0);
    chk("R9 wake dropped", wake, 0);

    frame(3, 32'h0, 32'h0, 32'h99995566, 0);
    chk("R5 masked bytes ignored after skip", det, 1);
    clear_all();

    frame(3, 32'hCAFEF00D, 32'h0, 32'h12345678, 0);
    chk("R4 skip on second word", det, 1);
    clear_all();

    frame(3, 32'hCAFEF00D, 32'h12345678, 32'h0, 0);
    chk("R4 early dword not compared", det, 0);
    chk("R2 disabled pattern silent", det, 0);
    clear_all();

    frame(1, 32'hDEADBEEF, 0, 0, 0);
    chk("R3 pointer from word 1", det, 1);
    clear_all();

    frame(1, 32'hAABBCCDD, 0, 0, 0);
    frame(1, 32'h11223344, 0, 0, 0);
    chk("R6 new frame restarts tracker", det, 0);
    clear_all();

    frame(3, 32'hAABBCCD0, 32'hAABBCCDD, 32'h11223344, 0);
    chk("R6 mismatch kills tracker", det, 0);
    clear_all();

    susp = 0;
    frame(2, 32'hAABBCCDD, 32'h11223344, 0, 0);
    chk("R7 gate closed ignores frame", det, 0);
    susp = 1;
    clear_all();

    wr(6'd3, {32'h55555555, 8'h8F});
    frame(2, 32'hAABBCCDD, 32'h11223344, 0, 0);
    chk("R1 write locked in mode", det, 1);
    clear_all();

    frame(2, 32'hAABBCCDD, 32'h11223344, 0, 1);
    chk("R8 set wins over clear", det, 1);
    clear_all();
    chk("R8 clear after set", det, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule